// File: doc/BRIEF.md
# GPIO port with peripheral override

This block controls a bidirectional port of `NPIN` pins (eight by default). Every pin runs the same logic. Software sets the pin direction, output value, open-drain mode and pull-up through a small register interface. A per-pin alternate-function enable hands the pin's direction and output value to a peripheral. The block drives the pad controls: output enable, output value and pull-up enable. It takes the raw pad level and passes it through a two-flop synchronizer. The synchronized level is returned both as a register readback and on the peripheral input bus.

Each pin can raise an interrupt. A change of the synchronized level in the selected direction, rising or falling, sets a sticky per-pin flag. Software clears a flag by writing a one to it. If a new edge arrives in the same cycle as the clear, the edge wins. A single request line is the OR of all flags whose enable is set.

The register interface is plain and has no back-pressure. A write takes effect at the clock edge where `cfg_we` is high. `cfg_rdata` follows `cfg_addr` combinationally.

Top module: `gpio_altfn_port`

## Requirements
- R1: After reset the direction register is 0 and the output register is all ones. Every flag is 0, no pad is driven (`pad_oe` = 0, `pad_out` = 0) and every pull-up is on (`pad_pu` all ones).
- R2: A pin with effective direction 1 (output) and open-drain mode 0 is driven: `pad_oe` = 1, `pad_out` = effective output value, `pad_pu` = 0.
- R3: A pin with effective direction 0 (input) is not driven (`pad_oe` = 0, `pad_out` = 0). Its `pad_pu` equals its bit in the output register (1 = weak pull-up, 0 = high impedance).
- R4: A pin with effective direction 1 and open-drain mode 1 behaves as follows. An output value of 0 drives the pad low (`pad_oe` = 1, `pad_out` = 0). An output value of 1 releases the pad (`pad_oe` = 0) and turns on its pull-up. An open-drain pin never drives high.
- R5: When a pin's alternate-function enable bit is 1, its effective direction and output value are `alt_dir` and `alt_out`. The direction and output registers then have no effect on `pad_oe` or `pad_out` for that pin.
- R6: The pad level appears in the input register and on `alt_in` two clock edges after it changes, in every mode.
- R7: An edge-select bit of 0 selects rising edges and 1 selects falling edges. A synchronized change of the selected polarity sets the pin's flag three clock edges after the pad change. A change of the other polarity leaves the flag alone.
- R8: Flags are sticky. Writing a 1 to a flag bit clears it, and writing 0 leaves it unchanged.
- R9: If a flag-setting edge and a clear of the same bit take effect on the same clock edge, the flag ends up set.
- R10: `irq` is high exactly when some pin has both its flag and its interrupt-enable bit set.
- R11: Writing the edge-select register while the pad level is steady sets no flag.
- R12: The register map is 0 direction, 1 output, 2 input (read-only; writes are ignored), 3 open-drain mode, 4 alternate-function enable, 5 interrupt enable, 6 edge select, 7 flags (write 1 to clear). Bit i of each register belongs to pin i. Writable registers read back their last written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | NPIN | Write data |
| cfg_rdata | output | NPIN | Read data for `cfg_addr` |
| alt_dir | input | NPIN | Peripheral direction per pin (1 = output) |
| alt_out | input | NPIN | Peripheral output value per pin |
| alt_in | output | NPIN | Synchronized pad level for peripherals |
| pad_in | input | NPIN | Raw pad level |
| pad_oe | output | NPIN | Pad output enable |
| pad_out | output | NPIN | Pad output value |
| pad_pu | output | NPIN | Pad weak pull-up enable |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench sets a flag clear and a fresh edge on the same clock edge. A design that gives the clear priority loses that interrupt, and one that clears the whole register loses the neighbouring flag. It samples the flags at exactly two and three edges after a pad change. This catches a missing synchronizer stage or an edge compare taken before the history is valid, which would raise spurious flags just after reset. It puts an alternate-function pin next to register-controlled pins and rewrites the registers. A leaking override shows up as a changed `pad_oe` or `pad_out`. It also toggles the edge-select bits on a steady pad, where a design that decodes polarity from the select would set flags by itself.

// File: rtl/gpio_altfn_pkg.sv
package gpio_altfn_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_DIR    = 3'd0,
    REG_OUT    = 3'd1,
    REG_IN     = 3'd2,
    REG_ODRAIN = 3'd3,
    REG_ALTEN  = 3'd4,
    REG_IRQEN  = 3'd5,
    REG_EDGE   = 3'd6,
    REG_FLAG   = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/port_in_sync.sv
module port_in_sync #(
  parameter int NPIN   = 8,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] raw_i,
  output logic [NPIN-1:0] sync_o
);
  logic [NPIN-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= raw_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/port_csr.sv
module port_csr
  import gpio_altfn_pkg::*;
#(
  parameter int NPIN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NPIN-1:0]   wdata_i,
  output logic [NPIN-1:0]   rdata_o,
  input  logic [NPIN-1:0]   level_i,
  input  logic [NPIN-1:0]   flag_i,
  output logic [NPIN-1:0]   dir_o,
  output logic [NPIN-1:0]   out_o,
  output logic [NPIN-1:0]   odrain_o,
  output logic [NPIN-1:0]   alten_o,
  output logic [NPIN-1:0]   irqen_o,
  output logic [NPIN-1:0]   edge_o,
  output logic [NPIN-1:0]   clr_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_o    <= '0;
      out_o    <= '1;
      odrain_o <= '0;
      alten_o  <= '0;
      irqen_o  <= '0;
      edge_o   <= '0;
    end else if (we_i) begin
      case (reg_sel_e'(addr_i))
        REG_DIR:    dir_o    <= wdata_i;
        REG_OUT:    out_o    <= wdata_i;
        REG_ODRAIN: odrain_o <= wdata_i;
        REG_ALTEN:  alten_o  <= wdata_i;
        REG_IRQEN:  irqen_o  <= wdata_i;
        REG_EDGE:   edge_o   <= wdata_i;
        default: ;
      endcase
    end
  end

  assign clr_o = (we_i && reg_sel_e'(addr_i) == REG_FLAG) ? wdata_i : '0;

  always_comb begin
    case (reg_sel_e'(addr_i))
      REG_DIR:    rdata_o = dir_o;
      REG_OUT:    rdata_o = out_o;
      REG_IN:     rdata_o = level_i;
      REG_ODRAIN: rdata_o = odrain_o;
      REG_ALTEN:  rdata_o = alten_o;
      REG_IRQEN:  rdata_o = irqen_o;
      REG_EDGE:   rdata_o = edge_o;
      REG_FLAG:   rdata_o = flag_i;
      default:    rdata_o = '0;
    endcase
  end

  // R12
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(we_i && reg_sel_e'(addr_i) == REG_DIR) |=> $stable(dir_o));
endmodule

// File: rtl/port_edge_flags.sv
module port_edge_flags #(
  parameter int NPIN = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] level_i,
  input  logic [NPIN-1:0] falling_i,
  input  logic [NPIN-1:0] clr_i,
  output logic [NPIN-1:0] flag_o
);
  localparam int PRIME_LEN = 3;

  logic [NPIN-1:0]      prev_q;
  logic [PRIME_LEN-1:0] prime_q;
  logic [NPIN-1:0]      hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      prime_q <= '0;
      flag_o  <= '0;
    end else begin
      prev_q  <= level_i;
      prime_q <= {prime_q[PRIME_LEN-2:0], 1'b1};
      flag_o  <= (flag_o & ~clr_i) | hit;
    end
  end

  // a change toward the selected polarity; history must be valid first
  assign hit = {NPIN{prime_q[PRIME_LEN-1]}} & (level_i ^ prev_q) & (level_i ^ falling_i);

  for (genvar i = 0; i < NPIN; i++) begin : g_chk
    // R7
    flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_o[i]) |-> $past(level_i[i] != prev_q[i]));
    // R8
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o[i] && !clr_i[i]) |=> flag_o[i]);
    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[i] && clr_i[i]) |=> flag_o[i]);
    // R11
    steady_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (level_i[i] == prev_q[i] && !flag_o[i]) |=> !flag_o[i]);
  end
endmodule

// File: rtl/port_pad_drive.sv
module port_pad_drive #(
  parameter int NPIN = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] dir_i,
  input  logic [NPIN-1:0] out_i,
  input  logic [NPIN-1:0] odrain_i,
  input  logic [NPIN-1:0] alten_i,
  input  logic [NPIN-1:0] alt_dir_i,
  input  logic [NPIN-1:0] alt_out_i,
  output logic [NPIN-1:0] pad_oe_o,
  output logic [NPIN-1:0] pad_out_o,
  output logic [NPIN-1:0] pad_pu_o
);
  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    logic dir_e, val_e;

    assign dir_e = alten_i[i] ? alt_dir_i[i] : dir_i[i];
    assign val_e = alten_i[i] ? alt_out_i[i] : out_i[i];

    always_comb begin
      if (!dir_e) begin
        pad_oe_o[i]  = 1'b0;
        pad_out_o[i] = 1'b0;
        pad_pu_o[i]  = out_i[i];
      end else if (odrain_i[i]) begin
        pad_oe_o[i]  = ~val_e;
        pad_out_o[i] = 1'b0;
        pad_pu_o[i]  = val_e;
      end else begin
        pad_oe_o[i]  = 1'b1;
        pad_out_o[i] = val_e;
        pad_pu_o[i]  = 1'b0;
      end
    end

    // R4
    odrain_no_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      odrain_i[i] |-> !(pad_oe_o[i] && pad_out_o[i]));
    // R3
    input_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!alten_i[i] && !dir_i[i]) |-> (!pad_oe_o[i] && pad_pu_o[i] == out_i[i]));
    // R5
    alt_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (alten_i[i] && alt_dir_i[i] && !odrain_i[i]) |-> (pad_oe_o[i] && pad_out_o[i] == alt_out_i[i]));
  end
endmodule

// File: rtl/gpio_altfn_port.sv
module gpio_altfn_port
  import gpio_altfn_pkg::*;
#(
  parameter int NPIN        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [NPIN-1:0]   cfg_wdata,
  output logic [NPIN-1:0]   cfg_rdata,
  input  logic [NPIN-1:0]   alt_dir,
  input  logic [NPIN-1:0]   alt_out,
  output logic [NPIN-1:0]   alt_in,
  input  logic [NPIN-1:0]   pad_in,
  output logic [NPIN-1:0]   pad_oe,
  output logic [NPIN-1:0]   pad_out,
  output logic [NPIN-1:0]   pad_pu,
  output logic              irq
);
  logic [NPIN-1:0] level, flag, dir_r, out_r, od_r, alten_r, irqen_r, edge_r, clr;

  port_in_sync #(.NPIN(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw_i(pad_in), .sync_o(level)
  );

  port_csr #(.NPIN(NPIN)) u_csr (
    .clk(clk), .rst_n(rst_n), .we_i(cfg_we), .addr_i(cfg_addr),
    .wdata_i(cfg_wdata), .rdata_o(cfg_rdata), .level_i(level), .flag_i(flag),
    .dir_o(dir_r), .out_o(out_r), .odrain_o(od_r), .alten_o(alten_r),
    .irqen_o(irqen_r), .edge_o(edge_r), .clr_o(clr)
  );

  port_edge_flags #(.NPIN(NPIN)) u_flags (
    .clk(clk), .rst_n(rst_n), .level_i(level), .falling_i(edge_r),
    .clr_i(clr), .flag_o(flag)
  );

  port_pad_drive #(.NPIN(NPIN)) u_pads (
    .clk(clk), .rst_n(rst_n), .dir_i(dir_r), .out_i(out_r), .odrain_i(od_r),
    .alten_i(alten_r), .alt_dir_i(alt_dir), .alt_out_i(alt_out),
    .pad_oe_o(pad_oe), .pad_out_o(pad_out), .pad_pu_o(pad_pu)
  );

  assign alt_in = level;
  assign irq    = |(flag & irqen_r);

  // R10
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !cfg_we) |=> irq);
endmodule

// File: tb/test_gpio_altfn_port.sv
module test_gpio_altfn_port;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_we = 1'b0;
  logic [2:0]   cfg_addr = 3'd0;
  logic [N-1:0] cfg_wdata = '0;
  logic [N-1:0] cfg_rdata;
  logic [N-1:0] alt_dir = '0, alt_out = '0, alt_in;
  logic [N-1:0] pad_in = 8'h5A;
  logic [N-1:0] pad_oe, pad_out, pad_pu;
  logic         irq;

  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  gpio_altfn_port #(.NPIN(N)) i_gpio_altfn_port (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .alt_dir(alt_dir),
    .alt_out(alt_out), .alt_in(alt_in), .pad_in(pad_in), .pad_oe(pad_oe),
    .pad_out(pad_out), .pad_pu(pad_pu), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [N-1:0] exp);
    cfg_addr = a;
    #1;
    check(req, cfg_rdata, exp);
  endtask

  task automatic pads_chk(input string req, input logic [N-1:0] oe, input logic [N-1:0] o,
                          input logic [N-1:0] pu);
    #1;
    check({req, " oe"}, pad_oe, oe);
    check({req, " out"}, pad_out, o);
    check({req, " pu"}, pad_pu, pu);
  endtask

  task automatic t_reset();
    repeat (6) @(negedge clk);
    pads_chk("R1 reset pads", 8'h00, 8'h00, 8'hFF);
    rd_chk("R1 reset dir", 3'd0, 8'h00);
    rd_chk("R1 reset out", 3'd1, 8'hFF);
    rd_chk("R1 reset flags", 3'd7, 8'h00);
    check("R1 reset irq", irq, 0);
  endtask

  task automatic t_regs();
    wr(3'd3, 8'hA5); rd_chk("R12 odrain readback", 3'd3, 8'hA5);
    wr(3'd4, 8'h3C); rd_chk("R12 alten readback", 3'd4, 8'h3C);
    wr(3'd5, 8'h81); rd_chk("R12 irqen readback", 3'd5, 8'h81);
    wr(3'd6, 8'h42); rd_chk("R12 edge readback", 3'd6, 8'h42);
    wr(3'd2, 8'hFF); rd_chk("R12 input read-only", 3'd2, 8'h5A);
    wr(3'd3, 8'h00); wr(3'd4, 8'h00); wr(3'd5, 8'h00); wr(3'd6, 8'h00);
    rd_chk("R1 flags untouched", 3'd7, 8'h00);
  endtask

  task automatic t_pushpull();
    wr(3'd1, 8'hC3); wr(3'd0, 8'hFF);
    pads_chk("R2 push-pull", 8'hFF, 8'hC3, 8'h00);
  endtask

  task automatic t_input_pull();
    wr(3'd0, 8'h00); wr(3'd1, 8'h0F);
    pads_chk("R3 input pull select", 8'h00, 8'h00, 8'h0F);
  endtask

  task automatic t_opendrain();
    wr(3'd0, 8'hFF); wr(3'd3, 8'hFF);
    pads_chk("R4 open-drain", 8'hF0, 8'h00, 8'h0F);
    wr(3'd3, 8'hF0);
    pads_chk("R4 mixed modes", 8'hFF, 8'h0F, 8'h00);
    wr(3'd3, 8'h00); wr(3'd0, 8'h00); wr(3'd1, 8'hFF);
  endtask

  task automatic t_special();
    alt_dir = 8'h03; alt_out = 8'h01;
    wr(3'd4, 8'h0F);
    pads_chk("R5 alt override", 8'h03, 8'h01, 8'hFC);
    wr(3'd1, 8'h00); wr(3'd0, 8'hFF);
    pads_chk("R5 registers ignored", 8'hF3, 8'h01, 8'h00);
    check("R6 alt_in in alt mode", alt_in, 8'h5A);
    wr(3'd4, 8'h00); wr(3'd0, 8'h00); wr(3'd1, 8'hFF);
    alt_dir = '0; alt_out = '0;
  endtask

  task automatic t_readback();
    @(negedge clk);
    pad_in = 8'h96;
    @(negedge clk); #1;
    check("R6 one edge: old level", alt_in, 8'h5A);
    @(negedge clk);
    rd_chk("R6 input register", 3'd2, 8'h96);
    check("R6 alt_in", alt_in, 8'h96);
    repeat (3) @(negedge clk);
    wr(3'd7, 8'hFF);
    rd_chk("R8 flags cleared", 3'd7, 8'h00);
  endtask

  task automatic t_edges();
    wr(3'd6, 8'hF0);
    @(negedge clk);
    pad_in = 8'h69;
    cfg_addr = 3'd7;
    repeat (2) @(negedge clk);
    #1 check("R7 no flag before third edge", cfg_rdata, 8'h00);
    @(negedge clk);
    #1 check("R7 rising/falling select", cfg_rdata, 8'h99);
  endtask

  task automatic t_w1c();
    wr(3'd7, 8'h00); rd_chk("R8 write zero keeps", 3'd7, 8'h99);
    wr(3'd7, 8'h09); rd_chk("R8 partial clear", 3'd7, 8'h90);
    wr(3'd7, 8'hFF); rd_chk("R8 full clear", 3'd7, 8'h00);
  endtask

  task automatic t_collision();
    wr(3'd6, 8'h00);
    @(negedge clk); pad_in = 8'h6B;
    repeat (4) @(negedge clk);
    rd_chk("R7 rising bit1", 3'd7, 8'h02);
    @(negedge clk); pad_in = 8'h6F;
    @(negedge clk);
    wr(3'd7, 8'h06);
    rd_chk("R9 set beats clear", 3'd7, 8'h04);
  endtask

  task automatic t_irq();
    wr(3'd5, 8'h00); #1 check("R10 masked", irq, 0);
    wr(3'd5, 8'h04); #1 check("R10 enabled flag", irq, 1);
    wr(3'd5, 8'hFB); #1 check("R10 other enables", irq, 0);
    wr(3'd5, 8'hFF); wr(3'd7, 8'hFF); #1 check("R10 cleared", irq, 0);
    wr(3'd5, 8'h00);
  endtask

  task automatic t_selchange();
    wr(3'd6, 8'hFF);
    repeat (5) @(negedge clk);
    rd_chk("R11 select to falling", 3'd7, 8'h00);
    wr(3'd6, 8'h00);
    repeat (5) @(negedge clk);
    rd_chk("R11 select to rising", 3'd7, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_pushpull();
    t_input_pull();
    t_opendrain();
    t_special();
    t_readback();
    t_edges();
    t_w1c();
    t_collision();
    t_irq();
    t_selchange();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule